// File: doc/BRIEF.md
# Acknowledged Link-Layer Sequencing Controller

This block is the control engine of a stop-and-wait link layer that sits above a byte-frame physical layer. An upper layer asks it to transmit a payload or to wait for one. The controller then tells the physical side which frame to emit (data, ACK, NACK or resync), when to start listening, and how to react to each completion, reception and error event. It keeps 2-bit modulo-4 transmit and receive sequence numbers, retries a failed exchange a bounded number of times, and escalates to a resync that restarts both counters when the retry budget runs out.

Frame assembly, CRC computation and length checking live elsewhere. A separate frame checker hands the controller the decoded header fields together with CRC-good and length-good flags for each received frame. An operation timeout is counted in clock cycles from the moment a request is accepted. Every action and report is a one-cycle pulse that is registered on the clock edge after the event that causes it.

Top module: `arq_seq_ctrl`

## Requirements
- R1: After reset no output pulses. Both sequence numbers start at 3, so the first data frame carries frame number 0 and ack number 3.
- R2: A transmit request is accepted only in idle with a nonzero length, and a receive request only in idle. Any other request yields a req_reject pulse one cycle later and no other action.
- R3: Each new data frame increments the transmit number modulo 4 and carries the current receive number as its ack number. send_kind encodes 0=data, 1=ACK, 2=NACK, 3=resync.
- R4: A physical error (ev_err) while sending, while waiting for a reply, or while sending an ACK retransmits the stored data frame with an unchanged frame number.
- R5: When the retransmit count equals RETRY_LIMIT, the next retry clears the count and sends a resync with ack and frame numbers 0. Both sequence numbers are reset to 3. After the completion event of the resync, the data frame is resent with a newly advanced number, which is 0.
- R6: In transmit mode, a valid ACK control frame (seqctr 0, frame number 0, ack number equal to the transmit number) pulses rpt_tx_ok. If the ack number does not match, the frame is discarded and recv_req is issued again with no report.
- R7: A valid NACK control frame (seqctr 1) whose ack number matches causes a retransmission of the data frame.
- R8: An in-sequence data frame is one whose frame number is the receive number plus 1, with seqctr 0 and a matching ack number. It advances the receive number and sends an ACK that carries the new number. On the ACK's ev_done the controller pulses rpt_rx_ok in receive-only mode, or both rpt_rx_ok and rpt_tx_ok in transmit mode.
- R9: A valid data frame with an unexpected frame number is answered with an ACK that carries the current receive number. After that ACK's completion, recv_req is issued again and nothing is reported.
- R10: A data frame with a failed CRC or length check is answered with a NACK whose ack number is the receive number plus 1, modulo 4. The controller then waits for the NACK's completion and listens again.
- R11: A retry attempted after TIMEOUT_CYC cycles have elapsed since acceptance enters the error path and ends with an rpt_err pulse.
- R12: ev_fatal outside idle forces the error path. If no resync has been sent since the last data frame, a resync is sent first, and rpt_err follows that resync's completion event.
- R13: At most one of send_req, recv_req, a success report, rpt_err fires in any cycle. ACK and NACK frames always carry frame number 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_req | input | 1 | Upper-layer transmit request pulse |
| tx_len | input | LEN_W | Payload length of the transmit request |
| rx_req | input | 1 | Upper-layer receive-only request pulse |
| ev_done | input | 1 | Physical layer finished sending a frame |
| ev_err | input | 1 | Physical layer send or receive failure |
| ev_fatal | input | 1 | Fatal physical-layer failure |
| ev_rcvd | input | 1 | A frame was received; the fields below are valid |
| rx_is_ctrl | input | 1 | Received frame is a control frame |
| rx_crc_ok | input | 1 | Received CRC matched |
| rx_len_ok | input | 1 | Received length fields are consistent for the frame type |
| rx_seqctr | input | 2 | Sequence-control code: 0 ACK, 1 NACK, 2 resync, 3 reserved |
| rx_frnr | input | SEQ_W | Frame number of the received frame |
| rx_acknr | input | SEQ_W | Ack number of the received frame |
| send_req | output | 1 | Pulse: emit a frame of kind send_kind |
| send_kind | output | 2 | 0 data, 1 ACK, 2 NACK, 3 resync |
| send_frnr | output | SEQ_W | Frame number for the frame to emit |
| send_acknr | output | SEQ_W | Ack number for the frame to emit |
| recv_req | output | 1 | Pulse: start receiving a frame |
| rpt_tx_ok | output | 1 | Pulse: transmission acknowledged |
| rpt_rx_ok | output | 1 | Pulse: a payload was received and acknowledged |
| rpt_err | output | 1 | Pulse: operation ended in error |
| req_reject | output | 1 | Pulse: upper-layer request refused |

## Verification
The assertions assume that each input event is a single-cycle pulse and that no two events share a cycle. They also assume that ev_rcvd arrives only while the controller is listening, with its header fields held valid in that same cycle. The stimulus respects this by driving one event at a time, and only after the output action that invites it has been observed. Random delays and random payload lengths are inserted between those steps, so the gaps change but the ordering stays legal.

// File: rtl/arq_pkg.sv
// Shared types for the link-layer sequencing controller.
// Assumes a 2-bit sequence-control code carried in every received header.
package arq_pkg;
    typedef enum logic [3:0] {
        ST_UNINIT, ST_IDLE, ST_TX, ST_RX, ST_ACK, ST_RESEND,
        ST_NACK, ST_ERROR, ST_DISCARD, ST_RX_DATA, ST_RX_CTRL
    } arq_state_e;

    typedef enum logic [1:0] {
        FK_DATA = 2'd0, FK_ACK = 2'd1, FK_NACK = 2'd2, FK_RESYNC = 2'd3
    } frame_kind_e;

    localparam logic [1:0] SC_ACK    = 2'd0;
    localparam logic [1:0] SC_NACK   = 2'd1;
    localparam logic [1:0] SC_RESYNC = 2'd2;
    localparam logic [1:0] SC_RFU    = 2'd3;
endpackage

// File: rtl/arq_seq_track.sv
// Transmit and receive sequence counters, wrapping modulo 2**SEQ_W.
// Assumes restart and advance commands never conflict; restart wins.
module arq_seq_track #(
    parameter int SEQ_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             adv_tx,
    input  logic             adv_rx,
    output logic [SEQ_W-1:0] tx_seq,
    output logic [SEQ_W-1:0] rx_seq
);
    localparam logic [SEQ_W-1:0] SEQ_TOP = '1;

    // Counter update: reset or restart to all-ones, else advance on command.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tx_seq <= SEQ_TOP;
            rx_seq <= SEQ_TOP;
        end else begin
            if (adv_tx) tx_seq <= tx_seq + SEQ_W'(1);
            if (adv_rx) rx_seq <= rx_seq + SEQ_W'(1);
        end
    end
endmodule

// File: rtl/arq_retry_timer.sv
// Retransmit counter and operation-elapsed timer.
// Assumes op_start marks the acceptance of a new operation.
module arq_retry_timer #(
    parameter int RETRY_LIMIT = 3,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic retry_clr,
    input  logic retry_inc,
    output logic at_limit,
    output logic expired
);
    localparam int RW = $clog2(RETRY_LIMIT + 2);
    localparam int TW = $clog2(TIMEOUT_CYC + 2);
    localparam logic [RW-1:0] LIM = RW'(RETRY_LIMIT);
    localparam logic [TW-1:0] TMO = TW'(TIMEOUT_CYC);

    logic [RW-1:0] retry_cnt;
    logic [TW-1:0] elapsed;

    // Retry count: clear takes priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n || retry_clr) retry_cnt <= '0;
        else if (retry_inc)      retry_cnt <= retry_cnt + RW'(1);
    end

    // Elapsed cycles since acceptance, saturating at the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || op_start) elapsed <= '0;
        else if (!expired)      elapsed <= elapsed + TW'(1);
    end

    assign at_limit = (retry_cnt == LIM);
    assign expired  = (elapsed >= TMO);
endmodule

// File: rtl/arq_seq_ctrl.sv
// Stop-and-wait link-layer sequencing controller (top).
// Decides which frame to emit, when to listen and what to report, from
// single-cycle physical events and pre-validated received header fields.
// Assumes one input event per cycle; all outputs are registered pulses.
module arq_seq_ctrl
    import arq_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int SEQ_W       = 2,
    parameter int RETRY_LIMIT = 3,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_req,
    input  logic [LEN_W-1:0] tx_len,
    input  logic             rx_req,
    input  logic             ev_done,
    input  logic             ev_err,
    input  logic             ev_fatal,
    input  logic             ev_rcvd,
    input  logic             rx_is_ctrl,
    input  logic             rx_crc_ok,
    input  logic             rx_len_ok,
    input  logic [1:0]       rx_seqctr,
    input  logic [SEQ_W-1:0] rx_frnr,
    input  logic [SEQ_W-1:0] rx_acknr,
    output logic             send_req,
    output logic [1:0]       send_kind,
    output logic [SEQ_W-1:0] send_frnr,
    output logic [SEQ_W-1:0] send_acknr,
    output logic             recv_req,
    output logic             rpt_tx_ok,
    output logic             rpt_rx_ok,
    output logic             rpt_err,
    output logic             req_reject
);
    arq_state_e st, n_st;
    logic pend, n_pend, rx_only, n_rxo, resynced, n_rsy;
    logic c_adv_tx, c_adv_rx, c_restart, c_rclr, c_rinc, c_start;
    logic at_limit, expired;
    logic [SEQ_W-1:0] tx_seq, rx_seq, tx_nx, rx_nx;
    logic n_send, n_recv, n_txok, n_rxok, n_err, n_rej;
    frame_kind_e n_kind;
    logic [SEQ_W-1:0] n_ak, n_fr;
    logic cap_ctrl, cap_good;
    logic [1:0] cap_sc;
    logic [SEQ_W-1:0] cap_fr, cap_ak;
    logic tx_go, rx_go, any_ev;

    arq_seq_track #(.SEQ_W(SEQ_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .restart(c_restart),
        .adv_tx(c_adv_tx), .adv_rx(c_adv_rx),
        .tx_seq(tx_seq), .rx_seq(rx_seq)
    );

    arq_retry_timer #(.RETRY_LIMIT(RETRY_LIMIT), .TIMEOUT_CYC(TIMEOUT_CYC)) u_rt (
        .clk(clk), .rst_n(rst_n), .op_start(c_start),
        .retry_clr(c_rclr), .retry_inc(c_rinc),
        .at_limit(at_limit), .expired(expired)
    );

    assign tx_nx  = tx_seq + SEQ_W'(1);
    assign rx_nx  = rx_seq + SEQ_W'(1);
    assign tx_go  = (st == ST_IDLE) && tx_req && (tx_len != '0);
    assign rx_go  = (st == ST_IDLE) && rx_req && !tx_req;
    assign any_ev = ev_done || ev_err;

    // Next-state, command and output decision for the sequencing FSM.
    always_comb begin
        n_st = st; n_pend = pend; n_rxo = rx_only; n_rsy = resynced;
        c_adv_tx = 1'b0; c_adv_rx = 1'b0; c_restart = 1'b0;
        c_rclr = 1'b0; c_rinc = 1'b0; c_start = 1'b0;
        n_send = 1'b0; n_kind = FK_DATA; n_ak = '0; n_fr = '0;
        n_recv = 1'b0; n_txok = 1'b0; n_rxok = 1'b0; n_err = 1'b0;
        n_rej = (tx_req || rx_req) && !(tx_go || rx_go);
        if (ev_fatal && st != ST_IDLE && st != ST_UNINIT) begin
            n_st = ST_ERROR;
            n_pend = 1'b0;
        end else begin
            unique case (st)
                ST_UNINIT: n_st = ST_IDLE;
                ST_IDLE: begin
                    if (tx_go) begin
                        n_st = ST_TX; c_rclr = 1'b1; c_start = 1'b1; n_rxo = 1'b0;
                        c_adv_tx = 1'b1; n_rsy = 1'b0;
                        n_send = 1'b1; n_kind = FK_DATA; n_fr = tx_nx; n_ak = rx_seq;
                    end else if (rx_go) begin
                        n_st = ST_RX; c_rclr = 1'b1; c_start = 1'b1; n_rxo = 1'b1;
                        n_recv = 1'b1;
                    end
                end
                ST_TX: begin
                    if (ev_err) n_st = ST_RESEND;
                    else if (ev_done) begin
                        n_st = ST_RX; n_recv = 1'b1;
                    end
                end
                ST_RX: begin
                    if (ev_err) n_st = ST_RESEND;
                    else if (ev_rcvd) n_st = rx_is_ctrl ? ST_RX_CTRL : ST_RX_DATA;
                end
                ST_RX_DATA: begin
                    if (!cap_good || cap_sc == SC_RESYNC || cap_sc == SC_RFU) begin
                        n_st = ST_NACK;
                    end else if (cap_fr != rx_nx) begin
                        n_st = ST_DISCARD; n_pend = 1'b1;
                        n_send = 1'b1; n_kind = FK_ACK; n_ak = rx_seq;
                    end else if (cap_ak != tx_seq) begin
                        n_st = ST_DISCARD;
                    end else if (cap_sc == SC_NACK) begin
                        n_st = ST_RESEND;
                    end else begin
                        n_st = ST_ACK; c_adv_rx = 1'b1; c_rclr = 1'b1;
                        n_send = 1'b1; n_kind = FK_ACK; n_ak = rx_nx;
                    end
                end
                ST_RX_CTRL: begin
                    if (rx_only ^ (cap_sc == SC_RESYNC)) n_st = ST_DISCARD;
                    else if (!cap_ctrl)                  n_st = ST_RESEND;
                    else if (!cap_good)                  n_st = ST_DISCARD;
                    else if (cap_sc == SC_RESYNC) begin
                        n_st = ST_DISCARD; c_restart = 1'b1; n_rsy = 1'b1;
                    end else if (cap_fr != '0 || cap_sc == SC_RFU || cap_ak != tx_seq) begin
                        n_st = ST_DISCARD;
                    end else if (cap_sc == SC_NACK) begin
                        n_st = ST_RESEND;
                    end else begin
                        n_st = ST_IDLE; n_txok = 1'b1;
                    end
                end
                ST_DISCARD: begin
                    if (pend) begin
                        if (any_ev) n_pend = 1'b0;
                    end else begin
                        n_st = ST_RX; n_recv = 1'b1;
                    end
                end
                ST_ACK: begin
                    if (ev_err) n_st = ST_RESEND;
                    else if (ev_done) begin
                        n_st = ST_IDLE; n_rxok = 1'b1; n_txok = !rx_only;
                    end
                end
                ST_NACK: begin
                    n_st = ST_TX;
                    n_send = 1'b1; n_kind = FK_NACK; n_ak = rx_nx;
                end
                ST_RESEND: begin
                    if (pend) begin
                        if (any_ev) n_pend = 1'b0;
                    end else if (expired) begin
                        n_st = ST_ERROR;
                    end else if (at_limit) begin
                        c_rclr = 1'b1; c_restart = 1'b1; n_rsy = 1'b1; n_pend = 1'b1;
                        n_send = 1'b1; n_kind = FK_RESYNC;
                    end else begin
                        n_st = ST_TX; c_rinc = 1'b1; c_adv_tx = resynced; n_rsy = 1'b0;
                        n_send = 1'b1; n_kind = FK_DATA; n_ak = rx_seq;
                        n_fr = resynced ? tx_nx : tx_seq;
                    end
                end
                ST_ERROR: begin
                    if (pend) begin
                        if (any_ev || ev_rcvd) begin
                            n_st = ST_IDLE; n_pend = 1'b0; n_err = 1'b1;
                        end
                    end else if (!resynced) begin
                        c_restart = 1'b1; n_rsy = 1'b1; n_pend = 1'b1;
                        n_send = 1'b1; n_kind = FK_RESYNC;
                    end else begin
                        n_st = ST_IDLE; n_err = 1'b1;
                    end
                end
                default: begin
                    n_st = ST_IDLE; n_err = 1'b1;
                end
            endcase
        end
    end

    // State, mode flags and registered output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_UNINIT; pend <= 1'b0; rx_only <= 1'b0; resynced <= 1'b0;
            send_req <= 1'b0; send_kind <= FK_DATA; send_frnr <= '0; send_acknr <= '0;
            recv_req <= 1'b0; rpt_tx_ok <= 1'b0; rpt_rx_ok <= 1'b0;
            rpt_err <= 1'b0; req_reject <= 1'b0;
        end else begin
            st <= n_st; pend <= n_pend; rx_only <= n_rxo; resynced <= n_rsy;
            send_req <= n_send; send_kind <= n_kind; send_frnr <= n_fr; send_acknr <= n_ak;
            recv_req <= n_recv; rpt_tx_ok <= n_txok; rpt_rx_ok <= n_rxok;
            rpt_err <= n_err; req_reject <= n_rej;
        end
    end

    // Capture of the received header and check flags while listening.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_ctrl <= 1'b0; cap_good <= 1'b0; cap_sc <= SC_ACK;
            cap_fr <= '0; cap_ak <= '0;
        end else if (st == ST_RX && ev_rcvd) begin
            cap_ctrl <= rx_crc_ok;
            cap_good <= rx_crc_ok && rx_len_ok;
            cap_sc   <= rx_seqctr;
            cap_fr   <= rx_frnr;
            cap_ak   <= rx_acknr;
        end
    end
endmodule

// File: rtl/arq_seq_ctrl_chk.sv
// Property checker for the sequencing controller, attached by bind.
// Assumes the input protocol described in the brief.
module arq_seq_ctrl_chk #(
    parameter int SEQ_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_req,
    input logic             rx_req,
    input logic             ev_done,
    input logic             send_req,
    input logic [1:0]       send_kind,
    input logic [SEQ_W-1:0] send_frnr,
    input logic [SEQ_W-1:0] send_acknr,
    input logic             recv_req,
    input logic             rpt_tx_ok,
    input logic             rpt_rx_ok,
    input logic             rpt_err,
    input logic             req_reject
);
    assert_resync_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (send_req && send_kind == 2'd3) |-> (send_acknr == '0 && send_frnr == '0));

    assert_reject_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> $past(tx_req || rx_req));

    assert_one_action_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({send_req, recv_req, rpt_err, (rpt_tx_ok || rpt_rx_ok)}));

    assert_ctrl_frnr_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (send_req && (send_kind == 2'd1 || send_kind == 2'd2)) |-> send_frnr == '0);

    assert_rxok_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_rx_ok |-> $past(ev_done));
endmodule

bind arq_seq_ctrl arq_seq_ctrl_chk #(.SEQ_W(SEQ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .rx_req(rx_req), .ev_done(ev_done),
    .send_req(send_req), .send_kind(send_kind), .send_frnr(send_frnr),
    .send_acknr(send_acknr), .recv_req(recv_req), .rpt_tx_ok(rpt_tx_ok),
    .rpt_rx_ok(rpt_rx_ok), .rpt_err(rpt_err), .req_reject(req_reject)
);

// File: tb/arq_seq_ctrl_tb.sv
module arq_seq_ctrl_tb;
    localparam int TMO = 300;
    logic clk = 1'b0, rst_n = 1'b0;
    logic tx_req = 0, rx_req = 0, ev_done = 0, ev_err = 0, ev_fatal = 0, ev_rcvd = 0;
    logic [15:0] tx_len = 0;
    logic rx_is_ctrl = 0, rx_crc_ok = 0, rx_len_ok = 0;
    logic [1:0] rx_seqctr = 0, rx_frnr = 0, rx_acknr = 0;
    logic send_req, recv_req, rpt_tx_ok, rpt_rx_ok, rpt_err, req_reject;
    logic [1:0] send_kind, send_frnr, send_acknr;
    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [1:0] tseq, rseq;

    arq_seq_ctrl #(.LEN_W(16), .SEQ_W(2), .RETRY_LIMIT(3), .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_len(tx_len), .rx_req(rx_req),
        .ev_done(ev_done), .ev_err(ev_err), .ev_fatal(ev_fatal), .ev_rcvd(ev_rcvd),
        .rx_is_ctrl(rx_is_ctrl), .rx_crc_ok(rx_crc_ok), .rx_len_ok(rx_len_ok),
        .rx_seqctr(rx_seqctr), .rx_frnr(rx_frnr), .rx_acknr(rx_acknr),
        .send_req(send_req), .send_kind(send_kind), .send_frnr(send_frnr),
        .send_acknr(send_acknr), .recv_req(recv_req), .rpt_tx_ok(rpt_tx_ok),
        .rpt_rx_ok(rpt_rx_ok), .rpt_err(rpt_err), .req_reject(req_reject)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [11:0] e_send(logic [1:0] k, logic [1:0] ak, logic [1:0] fr);
        return {6'b000001, k, ak, fr};
    endfunction
    function automatic logic [11:0] e_recv();
        return {6'b000010, 6'b0};
    endfunction
    function automatic logic [11:0] e_rpt(logic tx, logic rx, logic er);
        return {1'b0, er, rx, tx, 2'b00, 6'b0};
    endfunction
    function automatic logic [11:0] e_rej();
        return {6'b100000, 6'b0};
    endfunction

    task automatic chk(input logic [11:0] act, input logic [11:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %03h expected %03h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait for the next output action and return it packed.
    task automatic obs(output logic [11:0] got);
        got = '0;
        for (int i = 0; i < 250; i++) begin
            if (send_req | recv_req | rpt_tx_ok | rpt_rx_ok | rpt_err | req_reject) begin
                got = {req_reject, rpt_err, rpt_rx_ok, rpt_tx_ok, recv_req, send_req,
                       send_kind, send_acknr, send_frnr};
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic expect_act(input logic [11:0] exp, input string req);
        logic [11:0] g;
        obs(g);
        chk(g, exp, req);
    endtask

    task automatic p_done();  ev_done = 1;  @(negedge clk); ev_done = 0;  endtask
    task automatic p_err();   ev_err = 1;   @(negedge clk); ev_err = 0;   endtask
    task automatic p_fatal(); ev_fatal = 1; @(negedge clk); ev_fatal = 0; endtask
    task automatic p_tx(input logic [15:0] len);
        tx_req = 1; tx_len = len; @(negedge clk); tx_req = 0; tx_len = 0;
    endtask
    task automatic p_rx(); rx_req = 1; @(negedge clk); rx_req = 0; endtask
    task automatic p_rcv(input logic ctl, input logic crc, input logic lok,
                         input logic [1:0] sc, input logic [1:0] fr, input logic [1:0] ak);
        rx_is_ctrl = ctl; rx_crc_ok = crc; rx_len_ok = lok;
        rx_seqctr = sc; rx_frnr = fr; rx_acknr = ak; ev_rcvd = 1;
        @(negedge clk);
        ev_rcvd = 0; rx_is_ctrl = 0; rx_crc_ok = 0; rx_len_ok = 0;
        rx_seqctr = 0; rx_frnr = 0; rx_acknr = 0;
    endtask

    // Successful transmit exchange, model-driven.
    task automatic tx_txn(input logic [15:0] len, input int d);
        p_tx(len);
        tseq = tseq + 2'd1;
        expect_act(e_send(2'd0, rseq, tseq), "R3 data frame numbering");
        wt(d); p_done();
        expect_act(e_recv(), "R3 listen after data");
        wt(d); p_rcv(1, 1, 1, 2'd0, 2'd0, tseq);
        expect_act(e_rpt(1, 0, 0), "R6 ACK control reports tx ok");
    endtask

    // Successful receive-only exchange, model-driven.
    task automatic rx_txn(input int d);
        p_rx();
        expect_act(e_recv(), "R8 listen on rx request");
        wt(d); p_rcv(0, 1, 1, 2'd0, rseq + 2'd1, tseq);
        rseq = rseq + 2'd1;
        expect_act(e_send(2'd1, rseq, 2'd0), "R8 ACK carries new rx number");
        wt(d); p_done();
        expect_act(e_rpt(0, 1, 0), "R8 rx ok in receive mode");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [11:0] g;
        int t0;
        logic seen;
        void'($urandom(32'd20240611));
        tseq = 2'd3; rseq = 2'd3;
        wt(5); rst_n = 1;
        // R1: quiet after reset
        for (int i = 0; i < 3; i++) begin
            chk({req_reject, rpt_err, rpt_rx_ok, rpt_tx_ok, recv_req, send_req, 6'b0},
                12'h000, "R1 quiet after reset");
            @(negedge clk);
        end
        // R2: zero length rejected
        p_tx(16'd0);
        expect_act(e_rej(), "R2 zero-length reject");
        // R1/R3: first data frame and reject while busy
        p_tx(16'd10);
        tseq = tseq + 2'd1;
        expect_act(e_send(2'd0, 2'd3, 2'd0), "R1 first data frame number 0 ack 3");
        p_rx();
        expect_act(e_rej(), "R2 reject while busy");
        p_done(); expect_act(e_recv(), "R3 listen");
        p_rcv(1, 1, 1, 2'd0, 2'd0, tseq);
        expect_act(e_rpt(1, 0, 0), "R6 tx ok");
        // R6: wrong ack number discarded
        p_tx(16'd3); tseq = tseq + 2'd1;
        expect_act(e_send(2'd0, rseq, tseq), "R3 second frame");
        p_done(); expect_act(e_recv(), "R3 listen");
        p_rcv(1, 1, 1, 2'd0, 2'd0, tseq + 2'd2);
        expect_act(e_recv(), "R6 wrong ack discarded, relisten");
        p_rcv(1, 1, 1, 2'd0, 2'd0, tseq);
        expect_act(e_rpt(1, 0, 0), "R6 tx ok after discard");
        // R7: NACK control triggers retransmit
        p_tx(16'd7); tseq = tseq + 2'd1;
        expect_act(e_send(2'd0, rseq, tseq), "R3 third frame");
        p_done(); expect_act(e_recv(), "R3 listen");
        p_rcv(1, 1, 1, 2'd1, 2'd0, tseq);
        expect_act(e_send(2'd0, rseq, tseq), "R7 NACK retransmits same number");
        p_done(); expect_act(e_recv(), "R7 listen");
        p_rcv(1, 1, 1, 2'd0, 2'd0, tseq);
        expect_act(e_rpt(1, 0, 0), "R7 tx ok");
        // R4: physical errors in TX and RX
        p_tx(16'd1); tseq = tseq + 2'd1;
        expect_act(e_send(2'd0, rseq, tseq), "R3 fourth frame");
        p_err();
        expect_act(e_send(2'd0, rseq, tseq), "R4 error in TX resends same number");
        p_done(); expect_act(e_recv(), "R4 listen");
        p_err();
        expect_act(e_send(2'd0, rseq, tseq), "R4 error in RX resends same number");
        p_done(); expect_act(e_recv(), "R4 listen");
        p_rcv(1, 1, 1, 2'd0, 2'd0, tseq);
        expect_act(e_rpt(1, 0, 0), "R4 tx ok");
        // R8: receive-only
        rx_txn(0);
        // R9: duplicate data frame
        p_rx(); expect_act(e_recv(), "R9 listen");
        p_rcv(0, 1, 1, 2'd0, rseq, tseq);
        expect_act(e_send(2'd1, rseq, 2'd0), "R9 out-of-seq ACK with current number");
        p_done();
        expect_act(e_recv(), "R9 relisten without report");
        p_rcv(0, 1, 1, 2'd0, rseq + 2'd1, tseq); rseq = rseq + 2'd1;
        expect_act(e_send(2'd1, rseq, 2'd0), "R8 in-seq ACK");
        p_done(); expect_act(e_rpt(0, 1, 0), "R8 rx ok");
        // R10: corrupted data frame
        p_rx(); expect_act(e_recv(), "R10 listen");
        p_rcv(0, 0, 1, 2'd0, rseq + 2'd1, tseq);
        expect_act(e_send(2'd2, rseq + 2'd1, 2'd0), "R10 NACK ack number rx+1");
        p_done(); expect_act(e_recv(), "R10 listen after NACK");
        p_rcv(0, 1, 1, 2'd0, rseq + 2'd1, tseq); rseq = rseq + 2'd1;
        expect_act(e_send(2'd1, rseq, 2'd0), "R10 ACK after recovery");
        p_done(); expect_act(e_rpt(0, 1, 0), "R10 rx ok");
        // R8: transmit mode with data reply
        p_tx(16'd4); tseq = tseq + 2'd1;
        expect_act(e_send(2'd0, rseq, tseq), "R3 data in tx mode");
        p_done(); expect_act(e_recv(), "R8 listen");
        p_rcv(0, 1, 1, 2'd0, rseq + 2'd1, tseq); rseq = rseq + 2'd1;
        expect_act(e_send(2'd1, rseq, 2'd0), "R8 ACK in tx mode");
        p_done(); expect_act(e_rpt(1, 1, 0), "R8 tx and rx ok");
        // R5: retry limit escalates to resync
        p_tx(16'd9); tseq = tseq + 2'd1;
        expect_act(e_send(2'd0, rseq, tseq), "R5 initial frame");
        for (int i = 0; i < 3; i++) begin
            p_err();
            expect_act(e_send(2'd0, rseq, tseq), "R5 retransmission before limit");
        end
        p_err();
        expect_act(e_send(2'd3, 2'd0, 2'd0), "R5 resync at limit");
        tseq = 2'd3; rseq = 2'd3;
        p_done();
        tseq = tseq + 2'd1;
        expect_act(e_send(2'd0, 2'd3, 2'd0), "R5 data after resync numbered 0");
        p_done(); expect_act(e_recv(), "R5 listen");
        p_rcv(1, 1, 1, 2'd0, 2'd0, tseq);
        expect_act(e_rpt(1, 0, 0), "R5 tx ok");
        // R12: fatal error
        p_tx(16'd2); tseq = tseq + 2'd1;
        expect_act(e_send(2'd0, rseq, tseq), "R12 data before fatal");
        p_fatal();
        expect_act(e_send(2'd3, 2'd0, 2'd0), "R12 resync after fatal");
        p_done();
        expect_act(e_rpt(0, 0, 1), "R12 error report");
        tseq = 2'd3; rseq = 2'd3;
        // R11: operation timeout
        t0 = cyc; seen = 0;
        p_tx(16'd5);
        for (int i = 0; i < 40 && !seen; i++) begin
            obs(g);
            if (g[10]) seen = 1;
            else if (g[6] && g[5:4] == 2'd0) begin wt(40); p_err(); end
            else if (g[6]) p_done();
            else if (g[7]) p_err();
        end
        chk({11'b0, seen}, 12'h001, "R11 timeout ends in error report");
        chk({11'b0, (cyc - t0) >= TMO}, 12'h001, "R11 error not before timeout");
        tseq = 2'd3; rseq = 2'd3;
        // Random mix
        for (int i = 0; i < 30; i++) begin
            int r;
            r = int'($urandom % 4);
            if (r < 2)       tx_txn(16'(1 + $urandom % 1000), int'($urandom % 8));
            else if (r == 2) rx_txn(int'($urandom % 8));
            else begin
                p_tx(16'd0);
                expect_act(e_rej(), "R2 random zero-length reject");
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule